// File: doc/BRIEF.md
# Speculative Load Alignment and Poison Tracker

This block sits beside the load pipeline and judges loads issued in a speculative, non-faulting form. For each such load it forms the effective address, checks memory alignment for the access size and register alignment for the destination, and keeps one deferred-fault flag per architectural register in two banks: integer and floating-point. A fault is never raised on the spot. Instead it is parked in the destination's flag. A destination also inherits a flag already set on a source register, and in that case the memory read is cancelled.

When the control inputs enable logging, every judged load is also recorded in a small table of status records, each with a companion effective-address register. The first free slot below a software-set count is used, and an error is reported when no slot is free. A separate clear operation removes flags, either one register or a whole bank, and drops the matching records.

The sequencing is a three-state machine. `S_IDLE` accepts work: a load request takes `S_IDLE -> S_CHECK`, and a clear request with no load request takes `S_IDLE -> S_CLEAR`. `S_CHECK` evaluates the load, updates flags and records, and returns `S_CHECK -> S_IDLE`. `S_CLEAR` applies the clear and returns `S_CLEAR -> S_IDLE`.

Top module: `ne_load_checker`

## Requirements
- R1: The effective address is `req_base + req_disp` when `req_use_disp` is 1, and `req_base + req_imm` otherwise (two's complement, wrapping at the address width). It is visible through the record address register of a logged load.
- R2: Size codes are: 0 unsigned byte, 1 signed byte, 2 unsigned halfword, 3 signed halfword, 4 word, 5 doubleword, 6 quadword, 7 reserved. Byte and reserved codes never fault. Halfwords fault when address bit 0 is 1. Words fault when address bits 1:0 are nonzero.
- R3: A doubleword has a memory fault when address bits 2:0 are nonzero, and a register fault when the target index is odd.
- R4: A quadword has a memory fault when address bits 3:0 are nonzero, and a register fault when the target index is not a multiple of 4.
- R5: On either fault, the target flag is set in the bank chosen by `req_fp` (1 = floating-point), the other bank is untouched, and `resp_load` is 1.
- R6: With no fault, if the selected bank's flag is set for the base register, or for the displacement register when `req_use_disp` is 1, the target flag is set and `resp_load` is 0. Otherwise the target flag is cleared and `resp_load` is 1.
- R7: With logging enabled (`ctl_valid` and `ctl_log` both 1), the load takes the lowest-indexed record whose valid bit is 0 among indices below `ctl_count`. If there is none, `resp_err` is 1, no record is written, and the flag update still happens.
- R8: A record read on `rd_rec` is, from MSB to LSB: valid, address-valid, fp, target index (6 bits), size code (3), own index (3), register-fault, memory-fault. A logged load writes valid=1 and address-valid=1 and puts the effective address in `rd_addr` of the same slot.
- R9: With logging disabled, no record changes on a load.
- R10: A clear with `clr_all`=1 zeroes every flag of the bank chosen by `clr_fp`. When logging is enabled, it also invalidates every valid record whose fp bit equals `clr_fp`.
- R11: A clear with `clr_all`=0 zeroes flag `clr_idx` of the chosen bank. When logging is enabled, it also invalidates valid records with that fp bit and target index.
- R12: After reset, `ready` is 1 and all flags and records are 0. A request is taken only while `ready` is 1, and `ready` then drops for one cycle. `resp_valid` pulses on the second rising edge after acceptance. When a load request and a clear request are presented together, the load is served and the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request |
| req_base | input | 32 | Base register value |
| req_disp | input | 32 | Displacement register value |
| req_imm | input | 32 | Immediate displacement |
| req_use_disp | input | 1 | 1 selects the displacement register |
| req_base_idx | input | 6 | Base register index |
| req_disp_idx | input | 6 | Displacement register index |
| req_tgt_idx | input | 6 | Destination register index |
| req_size | input | 3 | Access size code |
| req_fp | input | 1 | Destination bank (1 = floating-point) |
| clr_valid | input | 1 | Clear request |
| clr_all | input | 1 | Clear whole bank |
| clr_idx | input | 6 | Register to clear |
| clr_fp | input | 1 | Bank to clear |
| ctl_valid | input | 1 | Control word valid |
| ctl_log | input | 1 | Logging enable |
| ctl_count | input | 4 | Number of usable records |
| ready | output | 1 | Idle, request accepted |
| resp_valid | output | 1 | Load result pulse |
| resp_load | output | 1 | Load may proceed |
| resp_err | output | 1 | No free record |
| int_flags | output | 64 | Integer bank flags |
| fp_flags | output | 64 | Floating-point bank flags |
| rd_idx | input | 3 | Record read index |
| rd_rec | output | 17 | Record contents |
| rd_addr | output | 32 | Record effective address |

## Verification
The hardest condition to reach is the record-table-full error. It needs every record below the count limit to be valid at once, and those records can only be filled by logged loads. The stimulus lowers `ctl_count` to 4 and fills the slots with logged loads, so the next logged load finds no slot. Clearing one register later frees a low slot, and the bench confirms that the following load reuses that slot rather than a higher one. Poison propagation is likewise reached only by first planting a fault on a register and then naming it as a source.

// File: rtl/ne_pkg.sv
package ne_pkg;

    typedef enum logic [2:0] {
        SZ_UB  = 3'd0,
        SZ_SB  = 3'd1,
        SZ_UH  = 3'd2,
        SZ_SH  = 3'd3,
        SZ_W   = 3'd4,
        SZ_D   = 3'd5,
        SZ_Q   = 3'd6,
        SZ_RSV = 3'd7
    } size_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_CLEAR = 2'd2
    } st_e;

endpackage

// File: rtl/ne_align_chk.sv
module ne_align_chk
    import ne_pkg::*;
(
    input  logic [3:0] addr_lo,
    input  logic [2:0] size,
    input  logic [1:0] tgt_lo,
    output logic       mem_fault,
    output logic       reg_fault
);

    always_comb begin
        mem_fault = 1'b0;
        reg_fault = 1'b0;
        case (size)
            SZ_UH, SZ_SH: mem_fault = addr_lo[0];
            SZ_W:         mem_fault = |addr_lo[1:0];
            SZ_D: begin
                mem_fault = |addr_lo[2:0];
                reg_fault = tgt_lo[0];
            end
            SZ_Q: begin
                mem_fault = |addr_lo[3:0];
                reg_fault = |tgt_lo[1:0];
            end
            default: begin
                mem_fault = 1'b0;
                reg_fault = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ne_flag_bank.sv
module ne_flag_bank #(
    parameter int NREG = 64,
    parameter int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            wr_val,
    input  logic            clr_all,
    output logic [NREG-1:0] flags
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else if (clr_all)
            flags <= '0;
        else if (wr_en)
            flags[wr_idx] <= wr_val;
    end

    p_bank_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (flags == '0));

    p_bank_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> (flags[$past(wr_idx)] == $past(wr_val)));

endmodule

// File: rtl/ne_rec_file.sv
module ne_rec_file #(
    parameter int NREC = 8,
    parameter int RIW  = $clog2(NREC),
    parameter int IDXW = 6,
    parameter int AW   = 32,
    parameter int RW   = 3 + IDXW + 3 + RIW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIW:0]    limit,
    input  logic            alloc_en,
    input  logic            alloc_fp,
    input  logic [IDXW-1:0] alloc_drn,
    input  logic [2:0]      alloc_size,
    input  logic            alloc_rc,
    input  logic            alloc_mc,
    input  logic [AW-1:0]   alloc_addr,
    input  logic            clr_en,
    input  logic            clr_all,
    input  logic [IDXW-1:0] clr_idx,
    input  logic            clr_fp,
    input  logic [RIW-1:0]  rd_idx,
    output logic [RW-1:0]   rd_rec,
    output logic [AW-1:0]   rd_addr,
    output logic            free_ok,
    output logic [RIW-1:0]  free_idx,
    output logic [NREC-1:0] valid_vec
);

    typedef struct packed {
        logic            valid;
        logic            addr_valid;
        logic            is_fp;
        logic [IDXW-1:0] drn;
        logic [2:0]      size;
        logic [RIW-1:0]  self_idx;
        logic            reg_cause;
        logic            mem_cause;
    } rec_t;

    logic [NREC-1:0][RW-1:0] rec_bus;
    logic [NREC-1:0][AW-1:0] addr_bus;

    // lowest free slot below the limit: scan downwards so the lowest wins
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = NREC - 1; i >= 0; i--) begin
            if (i < int'(limit) && !valid_vec[i]) begin
                free_ok  = 1'b1;
                free_idx = RIW'(i);
            end
        end
    end

    for (genvar g = 0; g < NREC; g++) begin : g_slot
        rec_t          r;
        logic [AW-1:0] a;
        logic          take;
        logic          drop;

        assign take = alloc_en && free_ok && (free_idx == RIW'(g));
        assign drop = clr_en && r.valid && (r.is_fp == clr_fp) &&
                      (clr_all || (r.drn == clr_idx));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
                a <= '0;
            end else if (take) begin
                r <= '{valid: 1'b1, addr_valid: 1'b1, is_fp: alloc_fp,
                       drn: alloc_drn, size: alloc_size, self_idx: RIW'(g),
                       reg_cause: alloc_rc, mem_cause: alloc_mc};
                a <= alloc_addr;
            end else if (drop) begin
                r <= '0;
                a <= '0;
            end
        end

        assign rec_bus[g]   = r;
        assign addr_bus[g]  = a;
        assign valid_vec[g] = r.valid;
    end

    assign rd_rec  = rec_bus[rd_idx];
    assign rd_addr = addr_bus[rd_idx];

    p_alloc_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && free_ok) |=> valid_vec[$past(free_idx)]);

    p_alloc_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && free_ok) |=> (addr_bus[$past(free_idx)] == $past(alloc_addr)));

endmodule

// File: rtl/ne_load_checker.sv
module ne_load_checker
    import ne_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NREC = 8,
    parameter int AW   = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int RIW  = $clog2(NREC),
    localparam int RW   = 3 + IDXW + 3 + RIW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_base,
    input  logic [AW-1:0]   req_disp,
    input  logic [AW-1:0]   req_imm,
    input  logic            req_use_disp,
    input  logic [IDXW-1:0] req_base_idx,
    input  logic [IDXW-1:0] req_disp_idx,
    input  logic [IDXW-1:0] req_tgt_idx,
    input  logic [2:0]      req_size,
    input  logic            req_fp,
    input  logic            clr_valid,
    input  logic            clr_all,
    input  logic [IDXW-1:0] clr_idx,
    input  logic            clr_fp,
    input  logic            ctl_valid,
    input  logic            ctl_log,
    input  logic [RIW:0]    ctl_count,
    output logic            ready,
    output logic            resp_valid,
    output logic            resp_load,
    output logic            resp_err,
    output logic [NREG-1:0] int_flags,
    output logic [NREG-1:0] fp_flags,
    input  logic [RIW-1:0]  rd_idx,
    output logic [RW-1:0]   rd_rec,
    output logic [AW-1:0]   rd_addr
);

    st_e st, st_nx;

    // operands captured on acceptance
    logic [AW-1:0]   op_base, op_off;
    logic            op_use_disp, op_fp, op_all, op_log;
    logic [IDXW-1:0] op_bidx, op_didx, op_tgt;
    logic [2:0]      op_size;
    logic [RIW:0]    op_cnt;

    logic [1:0][NREG-1:0] bank_flags;
    logic [NREG-1:0]      sel_flags;
    logic [AW-1:0]        ea;
    logic                 mem_f, reg_f, fault, poison, new_flag, load_ok;
    logic                 wr_any, wr_val, wipe_any;
    logic                 free_ok;
    logic [RIW-1:0]       free_idx;
    logic [NREC-1:0]      valid_vec;
    logic                 alloc_en, rec_clr_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (req_valid)      st_nx = S_CHECK;
                else if (clr_valid) st_nx = S_CLEAR;
            end
            S_CHECK: st_nx = S_IDLE;
            S_CLEAR: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    assign ready = (st == S_IDLE);

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_base <= '0; op_off <= '0; op_use_disp <= 1'b0;
            op_fp <= 1'b0; op_all <= 1'b0; op_log <= 1'b0;
            op_bidx <= '0; op_didx <= '0; op_tgt <= '0;
            op_size <= '0; op_cnt <= '0;
        end else if (st == S_IDLE && (req_valid || clr_valid)) begin
            op_log <= ctl_valid && ctl_log;
            op_cnt <= ctl_count;
            if (req_valid) begin
                op_base     <= req_base;
                op_off      <= req_use_disp ? req_disp : req_imm;
                op_use_disp <= req_use_disp;
                op_bidx     <= req_base_idx;
                op_didx     <= req_disp_idx;
                op_tgt      <= req_tgt_idx;
                op_size     <= req_size;
                op_fp       <= req_fp;
                op_all      <= 1'b0;
            end else begin
                op_tgt <= clr_idx;
                op_fp  <= clr_fp;
                op_all <= clr_all;
            end
        end
    end

    // evaluation
    assign ea = op_base + op_off;

    ne_align_chk u_align (
        .addr_lo   (ea[3:0]),
        .size      (op_size),
        .tgt_lo    (op_tgt[1:0]),
        .mem_fault (mem_f),
        .reg_fault (reg_f)
    );

    assign sel_flags = bank_flags[op_fp];
    assign fault     = mem_f || reg_f;
    assign poison    = sel_flags[op_bidx] || (op_use_disp && sel_flags[op_didx]);
    assign new_flag  = fault || poison;
    assign load_ok   = fault || !poison;

    assign wr_any   = (st == S_CHECK) || (st == S_CLEAR && !op_all);
    assign wr_val   = (st == S_CHECK) ? new_flag : 1'b0;
    assign wipe_any = (st == S_CLEAR) && op_all;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic hit;
        assign hit = (b == 1) ? op_fp : !op_fp;
        ne_flag_bank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_any && hit),
            .wr_idx  (op_tgt),
            .wr_val  (wr_val),
            .clr_all (wipe_any && hit),
            .flags   (bank_flags[b])
        );
    end

    assign int_flags = bank_flags[0];
    assign fp_flags  = bank_flags[1];

    assign alloc_en   = (st == S_CHECK) && op_log;
    assign rec_clr_en = (st == S_CLEAR) && op_log;

    ne_rec_file #(.NREC(NREC), .RIW(RIW), .IDXW(IDXW), .AW(AW), .RW(RW)) u_recs (
        .clk        (clk),
        .rst_n      (rst_n),
        .limit      (op_cnt),
        .alloc_en   (alloc_en),
        .alloc_fp   (op_fp),
        .alloc_drn  (op_tgt),
        .alloc_size (op_size),
        .alloc_rc   (reg_f),
        .alloc_mc   (mem_f),
        .alloc_addr (ea),
        .clr_en     (rec_clr_en),
        .clr_all    (op_all),
        .clr_idx    (op_tgt),
        .clr_fp     (op_fp),
        .rd_idx     (rd_idx),
        .rd_rec     (rd_rec),
        .rd_addr    (rd_addr),
        .free_ok    (free_ok),
        .free_idx   (free_idx),
        .valid_vec  (valid_vec)
    );

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_load  <= 1'b0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= (st == S_CHECK);
            resp_load  <= (st == S_CHECK) && load_ok;
            resp_err   <= (st == S_CHECK) && op_log && !free_ok;
        end
    end

    logic [NREC-1:0] lim_mask;
    always_comb begin
        for (int i = 0; i < NREC; i++) lim_mask[i] = (i < int'(op_cnt));
    end

    p_poison_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_load) |-> bank_flags[op_fp][op_tgt]);

    p_fault_keeps_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CHECK && fault) |=> (resp_load && bank_flags[$past(op_fp)][$past(op_tgt)]));

    p_err_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> ((valid_vec | ~lim_mask) == '1));

    p_busy_after_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (req_valid || clr_valid)) |=> !ready);

endmodule

// File: tb/ne_load_checker_bench.sv
module ne_load_checker_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_use_disp = 0, req_fp = 0;
    logic [31:0] req_base = 0, req_disp = 0, req_imm = 0;
    logic [5:0]  req_base_idx = 0, req_disp_idx = 0, req_tgt_idx = 0;
    logic [2:0]  req_size = 0;
    logic        clr_valid = 0, clr_all = 0, clr_fp = 0;
    logic [5:0]  clr_idx = 0;
    logic        ctl_valid = 0, ctl_log = 0;
    logic [3:0]  ctl_count = 0;
    logic        ready, resp_valid, resp_load, resp_err;
    logic [63:0] int_flags, fp_flags;
    logic [2:0]  rd_idx = 0;
    logic [16:0] rd_rec;
    logic [31:0] rd_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ne_load_checker u_ne_load_checker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_base(req_base), .req_disp(req_disp), .req_imm(req_imm),
        .req_use_disp(req_use_disp), .req_base_idx(req_base_idx), .req_disp_idx(req_disp_idx),
        .req_tgt_idx(req_tgt_idx), .req_size(req_size), .req_fp(req_fp),
        .clr_valid(clr_valid), .clr_all(clr_all), .clr_idx(clr_idx), .clr_fp(clr_fp),
        .ctl_valid(ctl_valid), .ctl_log(ctl_log), .ctl_count(ctl_count),
        .ready(ready), .resp_valid(resp_valid), .resp_load(resp_load), .resp_err(resp_err),
        .int_flags(int_flags), .fp_flags(fp_flags),
        .rd_idx(rd_idx), .rd_rec(rd_rec), .rd_addr(rd_addr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [63:0] m_flags [2];
    logic [16:0] m_rec   [8];
    logic [31:0] m_addr  [8];

    logic [1:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // monitor: pops one expectation per result pulse
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R12", "unexpected resp_valid", 1, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(resp_load == e[1], t, "resp_load", resp_load, e[1]);
                chk(resp_err  == e[0], t, "resp_err",  resp_err,  e[0]);
            end
        end
    end

    task automatic check_flags(input string tag);
        chk(int_flags == m_flags[0], tag, "int_flags", int_flags, m_flags[0]);
        chk(fp_flags  == m_flags[1], tag, "fp_flags",  fp_flags,  m_flags[1]);
    endtask

    task automatic check_rec(input int i, input string tag);
        rd_idx = 3'(i);
        #1;
        chk(rd_rec == m_rec[i], tag, $sformatf("record %0d", i), 64'(rd_rec), 64'(m_rec[i]));
        chk(rd_addr == m_addr[i], tag, $sformatf("addr %0d", i), 64'(rd_addr), 64'(m_addr[i]));
    endtask

    task automatic model_load(input logic [31:0] base, disp, imm, input logic ud,
                              input int bi, di, ti, input logic [2:0] sz, input logic fp,
                              input logic cv, cl, input int cnt,
                              output logic e_load, output logic e_err);
        logic [31:0] ea;
        logic mf, rf, pois, f;
        int slot;
        ea = base + (ud ? disp : imm);
        mf = 0; rf = 0;
        case (sz)
            3'd2, 3'd3: mf = ea[0];
            3'd4: mf = |ea[1:0];
            3'd5: begin mf = |ea[2:0]; rf = ti[0]; end
            3'd6: begin mf = |ea[3:0]; rf = |ti[1:0]; end
            default: ;
        endcase
        f = mf | rf;
        pois = m_flags[fp][bi] | (ud & m_flags[fp][di]);
        e_load = f | !pois;
        e_err = 0;
        if (cv && cl) begin
            slot = -1;
            for (int i = 7; i >= 0; i--) if (i < cnt && !m_rec[i][16]) slot = i;
            if (slot < 0) e_err = 1;
            else begin
                m_rec[slot]  = {1'b1, 1'b1, fp, 6'(ti), sz, 3'(slot), rf, mf};
                m_addr[slot] = ea;
            end
        end
        m_flags[fp][ti] = f | pois;
    endtask

    task automatic drive_req(input logic [31:0] base, disp, imm, input logic ud,
                             input int bi, di, ti, input logic [2:0] sz, input logic fp,
                             input logic cv, cl, input int cnt);
        req_base = base; req_disp = disp; req_imm = imm; req_use_disp = ud;
        req_base_idx = 6'(bi); req_disp_idx = 6'(di); req_tgt_idx = 6'(ti);
        req_size = sz; req_fp = fp;
        ctl_valid = cv; ctl_log = cl; ctl_count = 4'(cnt);
        req_valid = 1;
    endtask

    task automatic do_load(input string tag, input logic [31:0] base, disp, imm,
                           input logic ud, input int bi, di, ti, input logic [2:0] sz,
                           input logic fp, input logic cv, cl, input int cnt);
        logic el, ee;
        @(negedge clk);
        model_load(base, disp, imm, ud, bi, di, ti, sz, fp, cv, cl, cnt, el, ee);
        exp_q.push_back({el, ee});
        tag_q.push_back(tag);
        drive_req(base, disp, imm, ud, bi, di, ti, sz, fp, cv, cl, cnt);
        @(negedge clk);
        req_valid = 0;
        chk(ready == 0, "R12", "ready while busy", ready, 0);
        while (exp_q.size() != 0) @(negedge clk);
        #1;
        check_flags(tag);
    endtask

    task automatic do_clear(input string tag, input logic all, input int idx,
                            input logic fp, input logic cv, cl);
        @(negedge clk);
        clr_all = all; clr_idx = 6'(idx); clr_fp = fp;
        ctl_valid = cv; ctl_log = cl;
        clr_valid = 1;
        @(negedge clk);
        clr_valid = 0;
        @(negedge clk);
        @(negedge clk);
        if (all) m_flags[fp] = '0;
        else m_flags[fp][idx] = 1'b0;
        if (cv && cl) begin
            for (int i = 0; i < 8; i++) begin
                if (m_rec[i][16] && m_rec[i][14] == fp && (all || m_rec[i][13:8] == 6'(idx))) begin
                    m_rec[i] = '0;
                    m_addr[i] = '0;
                end
            end
        end
        check_flags(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_flags[0] = '0; m_flags[1] = '0;
        for (int i = 0; i < 8; i++) begin m_rec[i] = '0; m_addr[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(ready == 1, "R12", "ready after reset", ready, 1);
        chk(resp_valid == 0, "R12", "resp_valid after reset", resp_valid, 0);
        check_flags("R12");
        check_rec(0, "R12");

        // R2 clean word, byte odd, half odd, word misaligned
        do_load("R2", 32'h100, 0, 32'h0, 0, 1, 0, 2, 3'd4, 0, 0, 0, 8);
        do_load("R2", 32'h101, 0, 32'h0, 0, 1, 0, 6, 3'd0, 0, 0, 0, 8);
        do_load("R2", 32'h101, 0, 32'h0, 0, 1, 0, 5, 3'd2, 0, 0, 0, 8);
        do_load("R2", 32'h102, 0, 32'h0, 0, 1, 0, 7, 3'd4, 0, 0, 0, 8);
        do_load("R2", 32'h103, 0, 32'h0, 0, 1, 0, 11, 3'd7, 0, 0, 0, 8);
        // R3 doubleword
        do_load("R3", 32'h8, 0, 0, 0, 1, 0, 3, 3'd5, 0, 0, 0, 8);
        do_load("R3", 32'h4, 0, 0, 0, 1, 0, 10, 3'd5, 0, 0, 0, 8);
        do_load("R3", 32'h10, 0, 0, 0, 1, 0, 12, 3'd5, 0, 0, 0, 8);
        // R4 quadword
        do_load("R4", 32'h20, 0, 0, 0, 1, 0, 14, 3'd6, 0, 0, 0, 8);
        do_load("R4", 32'h28, 0, 0, 0, 1, 0, 16, 3'd6, 0, 0, 0, 8);
        do_load("R4", 32'h30, 0, 0, 0, 1, 0, 20, 3'd6, 0, 0, 0, 8);
        // R6 poison from base, displacement ignored / used, fault overrides
        do_load("R6", 32'h40, 0, 0, 0, 5, 0, 30, 3'd4, 0, 0, 0, 8);
        do_load("R6", 32'h40, 0, 0, 0, 1, 5, 31, 3'd4, 0, 0, 0, 8);
        do_load("R6", 32'h40, 32'h4, 0, 1, 1, 5, 32, 3'd4, 0, 0, 0, 8);
        do_load("R5", 32'h41, 0, 0, 0, 5, 0, 33, 3'd4, 0, 0, 0, 8);

        // R1 and R8 logged loads: register displacement and negative immediate
        do_load("R1", 32'h100, 32'h23, 32'h0, 1, 1, 2, 9, 3'd2, 0, 1, 1, 8);
        check_rec(0, "R8");
        do_load("R1", 32'h200, 32'h0, 32'hFFFF_FFFC, 0, 1, 2, 8, 3'd4, 0, 1, 1, 8);
        check_rec(1, "R1");
        // R5 float bank only
        do_load("R5", 32'h1FE, 0, 0, 0, 1, 0, 9, 3'd4, 1, 1, 1, 8);
        check_rec(2, "R8");
        // R9 logging off
        do_load("R9", 32'h300, 0, 0, 0, 1, 0, 40, 3'd4, 0, 1, 0, 8);
        check_rec(3, "R9");
        // R7 fill up to count 4, then overflow
        do_load("R7", 32'h304, 0, 0, 0, 1, 0, 41, 3'd4, 0, 1, 1, 4);
        check_rec(3, "R7");
        do_load("R7", 32'h309, 0, 0, 0, 1, 0, 42, 3'd4, 0, 1, 1, 4);
        check_rec(4, "R7");
        do_load("R7", 32'h310, 0, 0, 0, 1, 0, 43, 3'd4, 0, 1, 1, 8);
        check_rec(4, "R7");

        // R11 clear one integer register with logging on
        do_clear("R11", 0, 9, 0, 1, 1);
        check_rec(0, "R11");
        check_rec(2, "R11");
        do_load("R7", 32'h320, 0, 0, 0, 1, 0, 44, 3'd2, 0, 1, 1, 8);
        check_rec(0, "R7");

        // R10 clear whole float bank with logging on
        do_clear("R10", 1, 0, 1, 1, 1);
        check_rec(2, "R10");
        check_rec(1, "R10");

        // R12 load and clear together: clear dropped
        @(negedge clk);
        begin
            logic el, ee;
            model_load(32'h405, 0, 0, 0, 1, 0, 50, 3'd4, 0, 0, 0, 8, el, ee);
            exp_q.push_back({el, ee});
            tag_q.push_back("R12");
            drive_req(32'h405, 0, 0, 0, 1, 0, 50, 3'd4, 0, 0, 0, 8);
            clr_all = 1; clr_fp = 0; clr_valid = 1;
            @(negedge clk);
            req_valid = 0; clr_valid = 0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (2) @(negedge clk);
            check_flags("R12");
        end

        // R10 clear whole integer bank with logging off: records stay
        do_clear("R10", 1, 0, 0, 0, 0);
        check_rec(0, "R10");
        check_rec(3, "R10");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R12", "pending results", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule